// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

The block sits after instruction decode in a two-pipe in-order core. Each cycle it takes two decoded instruction descriptors: the older one, bound for the primary pipe, and the younger one, which may share the issue slot on the secondary pipe. It decides whether the two may issue together. The older instruction always issues on the primary pipe. The younger one joins it only when both descriptors are valid and neither breaks a pairing rule. The rules cover microcode, multi-cycle operations, excess length, a displacement together with an immediate, and a 32-bit displacement on a vector- or mask-class prefix. A register dependency between the two also blocks pairing, unless the pair is one of three recognised dependent pairs.

The decision is registered. A one-bit grant and a one-hot reason code appear one clock after the descriptors are presented. When several causes apply at once, the reason code reports exactly one of them, chosen by a fixed priority. When pairing is granted, or when a pair is not even attempted, the reason code is zero.

Top module: `dual_issue_pairer`

## Requirements
- R1: When both descriptors are valid and no rule below blocks pairing, the grant output is 1 and the reason output is 0.
- R2: A register dependency exists when the younger instruction's srcA, srcB or dst equals the older instruction's dst. Register ID 0 means "no register" and never matches. Without an exception (R3), a dependency blocks pairing with reason bit 0 (value 6'h01).
- R3: Opcode classes are encoded 0 ALU, 1 compare, 2 conditional jump, 3 push, 4 pop, 5 other. The older/younger class pairs compare/jump, push/push and pop/pop are granted despite a register dependency. Any other class combination is subject to R2.
- R4: If either instruction has both a displacement and an immediate, pairing is blocked with reason bit 1 (6'h02).
- R5: If either instruction is longer than 8 bytes, pairing is blocked with reason bit 2 (6'h04). A length of exactly 8 is allowed.
- R6: Prefix classes are encoded 0 none, 1 vector, 2 mask, 3 legacy. An instruction of prefix class 1 or 2 that has a displacement with the 32-bit size flag set blocks pairing with reason bit 3 (6'h08). Class 3 with a 32-bit displacement, and class 1 or 2 with an 8-bit displacement, are allowed.
- R7: If either instruction is microcoded, pairing is blocked with reason bit 4 (6'h10).
- R8: If either instruction is not single-cycle, pairing is blocked with reason bit 5 (6'h20).
- R9: The reason output is one-hot or zero. When several causes apply, the reported bit follows this priority, highest first: microcode, multi-cycle, length, displacement-plus-immediate, prefixed 32-bit displacement, dependency.
- R10: If either valid input is low, both the grant and the reason output are 0.
- R11: The outputs change only on a rising clock edge, one cycle after the inputs are presented. While the synchronous active-low reset is asserted, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| uValid | input | 1 | Older descriptor valid |
| uLen | input | 4 | Older instruction length in bytes |
| uHasDisp | input | 1 | Older has displacement |
| uDisp32 | input | 1 | Older displacement is 32-bit |
| uHasImm | input | 1 | Older has immediate |
| uPrefix | input | 2 | Older prefix class |
| uUcode | input | 1 | Older is microcoded |
| uSingle | input | 1 | Older is single-cycle |
| uSrcA | input | 4 | Older source register A |
| uSrcB | input | 4 | Older source register B |
| uDst | input | 4 | Older destination register |
| uOp | input | 3 | Older opcode class |
| vValid | input | 1 | Younger descriptor valid |
| vLen | input | 4 | Younger instruction length in bytes |
| vHasDisp | input | 1 | Younger has displacement |
| vDisp32 | input | 1 | Younger displacement is 32-bit |
| vHasImm | input | 1 | Younger has immediate |
| vPrefix | input | 2 | Younger prefix class |
| vUcode | input | 1 | Younger is microcoded |
| vSingle | input | 1 | Younger is single-cycle |
| vSrcA | input | 4 | Younger source register A |
| vSrcB | input | 4 | Younger source register B |
| vDst | input | 4 | Younger destination register |
| vOp | input | 3 | Younger opcode class |
| pairGrant | output | 1 | Younger instruction may issue with the older one |
| pairReason | output | 6 | One-hot cause when pairing is refused |

## Verification
The pairing decision is tried with independent pairs, with read-after-write and write-after-write pairs, and with each of the three recognised dependent pairs. Comparing these shows that the exceptions apply only to the listed class combinations and that register 0 never counts as a dependency. Each rule is triggered alone, from either slot, next to its boundary value: length 8 against 9, an 8-bit against a 32-bit displacement, and a legacy against a vector prefix. This shows that every cause maps to its own reason bit. Vectors that trip several rules at once check the priority order, and vectors with one valid low check that no attempt is reported.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int unsigned LEN_W   = 4;
  localparam int unsigned REG_W   = 4;
  localparam int unsigned OP_W    = 3;
  localparam int unsigned PFX_W   = 2;
  localparam int unsigned NUM_SLOTS = 2;

  // Opcode classes
  localparam logic [OP_W-1:0] OP_ALU   = 3'd0;
  localparam logic [OP_W-1:0] OP_CMP   = 3'd1;
  localparam logic [OP_W-1:0] OP_JCC   = 3'd2;
  localparam logic [OP_W-1:0] OP_PUSH  = 3'd3;
  localparam logic [OP_W-1:0] OP_POP   = 3'd4;
  localparam logic [OP_W-1:0] OP_OTHER = 3'd5;

  // Prefix classes
  localparam logic [PFX_W-1:0] PFX_NONE   = 2'd0;
  localparam logic [PFX_W-1:0] PFX_VEC    = 2'd1;
  localparam logic [PFX_W-1:0] PFX_MASK   = 2'd2;
  localparam logic [PFX_W-1:0] PFX_LEGACY = 2'd3;

  // Reason bit positions
  localparam int unsigned RSN_W      = 6;
  localparam int unsigned RSN_DEP    = 0;
  localparam int unsigned RSN_DISPIM = 1;
  localparam int unsigned RSN_LEN    = 2;
  localparam int unsigned RSN_PFXD32 = 3;
  localparam int unsigned RSN_UCODE  = 4;
  localparam int unsigned RSN_MULTI  = 5;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             hasDisp;
    logic             disp32;
    logic             hasImm;
    logic [PFX_W-1:0] pfx;
    logic             ucode;
    logic             single;
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
    logic [REG_W-1:0] dst;
    logic [OP_W-1:0]  op;
  } instrDesc_t;

  typedef struct packed {
    logic dispImm;
    logic tooLong;
    logic pfxDisp32;
    logic ucode;
    logic multiCycle;
  } ruleFlags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             grant;
    logic [RSN_W-1:0] reason;
  } ctrlStrobe_t;
endpackage

// File: rtl/pair_rule_unit.sv
module pair_rule_unit
  import pair_pkg::*;
#(
  parameter int unsigned MAX_LEN = 8
) (
  input  instrDesc_t desc,
  output ruleFlags_t flags
);
  logic widePfx;

  always_comb begin
    widePfx          = (desc.pfx == PFX_VEC) || (desc.pfx == PFX_MASK);
    flags.dispImm    = desc.hasDisp && desc.hasImm;
    flags.tooLong    = (32'(desc.len) > MAX_LEN);
    flags.pfxDisp32  = widePfx && desc.hasDisp && desc.disp32;
    flags.ucode      = desc.ucode;
    flags.multiCycle = !desc.single;
  end
endmodule

// File: rtl/pair_dep_unit.sv
module pair_dep_unit
  import pair_pkg::*;
(
  input  instrDesc_t older,
  input  instrDesc_t younger,
  output logic       depHit,
  output logic       exceptOk
);
  logic olderWrites;

  always_comb begin
    olderWrites = (older.dst != '0);
    depHit = olderWrites &&
             ((younger.srcA == older.dst) ||
              (younger.srcB == older.dst) ||
              (younger.dst  == older.dst));
    exceptOk = ((older.op == OP_CMP)  && (younger.op == OP_JCC))  ||
               ((older.op == OP_PUSH) && (younger.op == OP_PUSH)) ||
               ((older.op == OP_POP)  && (younger.op == OP_POP));
  end
endmodule

// File: rtl/pair_datapath.sv
module pair_datapath
  import pair_pkg::*;
#(
  parameter int unsigned MAX_LEN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  instrDesc_t  uDesc,
  input  instrDesc_t  vDesc,
  input  ctrlStrobe_t strobe,
  output ruleFlags_t  anyFlags,
  output logic        depHit,
  output logic        exceptOk,
  output logic        grantQ,
  output logic [RSN_W-1:0] reasonQ
);
  instrDesc_t slotDesc  [NUM_SLOTS];
  ruleFlags_t slotFlags [NUM_SLOTS];

  assign slotDesc[0] = uDesc;
  assign slotDesc[1] = vDesc;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    pair_rule_unit #(.MAX_LEN(MAX_LEN)) i_rule (
      .desc  (slotDesc[s]),
      .flags (slotFlags[s])
    );
  end

  assign anyFlags = ruleFlags_t'(slotFlags[0] | slotFlags[1]);

  pair_dep_unit i_dep (
    .older    (uDesc),
    .younger  (vDesc),
    .depHit   (depHit),
    .exceptOk (exceptOk)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ  <= 1'b0;
      reasonQ <= '0;
    end else begin
      grantQ  <= strobe.grant;
      reasonQ <= strobe.reason;
    end
  end
endmodule

// File: rtl/pair_ctrl.sv
module pair_ctrl
  import pair_pkg::*;
(
  input  logic        bothValid,
  input  ruleFlags_t  anyFlags,
  input  logic        depHit,
  input  logic        exceptOk,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (bothValid) begin
      if (anyFlags.ucode)                strobe.reason[RSN_UCODE]  = 1'b1;
      else if (anyFlags.multiCycle)      strobe.reason[RSN_MULTI]  = 1'b1;
      else if (anyFlags.tooLong)         strobe.reason[RSN_LEN]    = 1'b1;
      else if (anyFlags.dispImm)         strobe.reason[RSN_DISPIM] = 1'b1;
      else if (anyFlags.pfxDisp32)       strobe.reason[RSN_PFXD32] = 1'b1;
      else if (depHit && !exceptOk)      strobe.reason[RSN_DEP]    = 1'b1;
      else                               strobe.grant              = 1'b1;
    end
  end
endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
  import pair_pkg::*;
#(
  parameter int unsigned MAX_PAIR_LEN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             uValid,
  input  logic [LEN_W-1:0] uLen,
  input  logic             uHasDisp,
  input  logic             uDisp32,
  input  logic             uHasImm,
  input  logic [PFX_W-1:0] uPrefix,
  input  logic             uUcode,
  input  logic             uSingle,
  input  logic [REG_W-1:0] uSrcA,
  input  logic [REG_W-1:0] uSrcB,
  input  logic [REG_W-1:0] uDst,
  input  logic [OP_W-1:0]  uOp,
  input  logic             vValid,
  input  logic [LEN_W-1:0] vLen,
  input  logic             vHasDisp,
  input  logic             vDisp32,
  input  logic             vHasImm,
  input  logic [PFX_W-1:0] vPrefix,
  input  logic             vUcode,
  input  logic             vSingle,
  input  logic [REG_W-1:0] vSrcA,
  input  logic [REG_W-1:0] vSrcB,
  input  logic [REG_W-1:0] vDst,
  input  logic [OP_W-1:0]  vOp,
  output logic             pairGrant,
  output logic [RSN_W-1:0] pairReason
);
  instrDesc_t  uDesc, vDesc;
  ruleFlags_t  anyFlags;
  ctrlStrobe_t strobe;
  logic        depHit, exceptOk;

  assign uDesc = '{len: uLen, hasDisp: uHasDisp, disp32: uDisp32, hasImm: uHasImm,
                   pfx: uPrefix, ucode: uUcode, single: uSingle, srcA: uSrcA,
                   srcB: uSrcB, dst: uDst, op: uOp};
  assign vDesc = '{len: vLen, hasDisp: vHasDisp, disp32: vDisp32, hasImm: vHasImm,
                   pfx: vPrefix, ucode: vUcode, single: vSingle, srcA: vSrcA,
                   srcB: vSrcB, dst: vDst, op: vOp};

  pair_datapath #(.MAX_LEN(MAX_PAIR_LEN)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .uDesc    (uDesc),
    .vDesc    (vDesc),
    .strobe   (strobe),
    .anyFlags (anyFlags),
    .depHit   (depHit),
    .exceptOk (exceptOk),
    .grantQ   (pairGrant),
    .reasonQ  (pairReason)
  );

  pair_ctrl i_ctrl (
    .bothValid (uValid && vValid),
    .anyFlags  (anyFlags),
    .depHit    (depHit),
    .exceptOk  (exceptOk),
    .strobe    (strobe)
  );
endmodule

// File: rtl/pair_checker.sv
module pair_checker
  import pair_pkg::*;
#(
  parameter int unsigned MAX_PAIR_LEN = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             uValid,
  input logic             vValid,
  input logic [LEN_W-1:0] uLen,
  input logic [LEN_W-1:0] vLen,
  input logic             uHasDisp,
  input logic             uHasImm,
  input logic             vHasDisp,
  input logic             vHasImm,
  input logic             uUcode,
  input logic             vUcode,
  input logic             pairGrant,
  input logic [RSN_W-1:0] pairReason
);
  // Set once the outputs have been loaded from live inputs
  logic armedQ;
  always_ff @(posedge clk) begin
    if (!rstN) armedQ <= 1'b0;
    else       armedQ <= 1'b1;
  end

  assert_reason_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pairReason));

  assert_grant_clean_R1: assert property (@(posedge clk) disable iff (!rstN)
    pairGrant |-> (pairReason == '0));

  assert_no_attempt_R10: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && !$past(uValid && vValid)) |-> (!pairGrant && pairReason == '0));

  assert_long_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && $past(uValid && vValid &&
      ((32'(uLen) > MAX_PAIR_LEN) || (32'(vLen) > MAX_PAIR_LEN)))) |-> !pairGrant);

  assert_dispimm_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && $past(uValid && vValid &&
      ((uHasDisp && uHasImm) || (vHasDisp && vHasImm)))) |-> !pairGrant);

  assert_ucode_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && $past(uValid && vValid && (uUcode || vUcode))) |->
      (pairReason == 6'h10));
endmodule

bind dual_issue_pairer pair_checker #(.MAX_PAIR_LEN(MAX_PAIR_LEN)) i_pair_checker (
  .clk        (clk),
  .rstN       (rstN),
  .uValid     (uValid),
  .vValid     (vValid),
  .uLen       (uLen),
  .vLen       (vLen),
  .uHasDisp   (uHasDisp),
  .uHasImm    (uHasImm),
  .vHasDisp   (vHasDisp),
  .vHasImm    (vHasImm),
  .uUcode     (uUcode),
  .vUcode     (vUcode),
  .pairGrant  (pairGrant),
  .pairReason (pairReason)
);

// File: tb/test_dual_issue_pairer.sv
module test_dual_issue_pairer;
  import pair_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic uValid, vValid;
  instrDesc_t uD, vD;
  logic pairGrant;
  logic [RSN_W-1:0] pairReason;

  dual_issue_pairer i_dual_issue_pairer (
    .clk(clk), .rstN(rstN),
    .uValid(uValid), .uLen(uD.len), .uHasDisp(uD.hasDisp), .uDisp32(uD.disp32),
    .uHasImm(uD.hasImm), .uPrefix(uD.pfx), .uUcode(uD.ucode), .uSingle(uD.single),
    .uSrcA(uD.srcA), .uSrcB(uD.srcB), .uDst(uD.dst), .uOp(uD.op),
    .vValid(vValid), .vLen(vD.len), .vHasDisp(vD.hasDisp), .vDisp32(vD.disp32),
    .vHasImm(vD.hasImm), .vPrefix(vD.pfx), .vUcode(vD.ucode), .vSingle(vD.single),
    .vSrcA(vD.srcA), .vSrcB(vD.srcB), .vDst(vD.dst), .vOp(vD.op),
    .pairGrant(pairGrant), .pairReason(pairReason)
  );

  typedef struct packed {
    logic       uv;
    instrDesc_t u;
    logic       vv;
    instrDesc_t v;
    logic       expG;
    logic [5:0] expR;
    logic [3:0] req;
  } vec_t;

  function automatic instrDesc_t mk(int len, bit d, bit d32, bit imm, int pfx, bit uc,
                                    bit sc, int sa, int sb, int ds, int op);
    instrDesc_t r;
    r.len = LEN_W'(len); r.hasDisp = d; r.disp32 = d32; r.hasImm = imm;
    r.pfx = PFX_W'(pfx); r.ucode = uc; r.single = sc;
    r.srcA = REG_W'(sa); r.srcB = REG_W'(sb); r.dst = REG_W'(ds); r.op = OP_W'(op);
    return r;
  endfunction

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    // R1 independent ALU pair
    '{1, mk(3,0,0,0,0,0,1,2,3,1,0), 1, mk(3,0,0,0,0,0,1,4,5,6,0), 1, 6'h00, 1},
    // R2 read after write
    '{1, mk(3,0,0,0,0,0,1,2,3,1,0), 1, mk(3,0,0,0,0,0,1,1,5,6,0), 0, 6'h01, 2},
    // R2 write after write
    '{1, mk(3,0,0,0,0,0,1,2,3,1,0), 1, mk(3,0,0,0,0,0,1,4,5,1,0), 0, 6'h01, 2},
    // R3 compare then jump
    '{1, mk(3,0,0,0,0,0,1,2,3,7,1), 1, mk(2,0,0,0,0,0,1,7,0,0,2), 1, 6'h00, 3},
    // R3 push/push
    '{1, mk(1,0,0,0,0,0,1,4,2,4,3), 1, mk(1,0,0,0,0,0,1,4,3,4,3), 1, 6'h00, 3},
    // R3 pop/pop
    '{1, mk(1,0,0,0,0,0,1,4,0,4,4), 1, mk(1,0,0,0,0,0,1,4,0,4,4), 1, 6'h00, 3},
    // R3 push then pop is not an exception
    '{1, mk(1,0,0,0,0,0,1,4,2,4,3), 1, mk(1,0,0,0,0,0,1,4,0,4,4), 0, 6'h01, 3},
    // R4 younger disp+imm
    '{1, mk(3,0,0,0,0,0,1,2,3,1,0), 1, mk(6,1,0,1,0,0,1,4,5,6,0), 0, 6'h02, 4},
    // R5 older length 9
    '{1, mk(9,0,0,0,0,0,1,2,3,1,0), 1, mk(3,0,0,0,0,0,1,4,5,6,0), 0, 6'h04, 5},
    // R5 younger length 8 allowed
    '{1, mk(3,0,0,0,0,0,1,2,3,1,0), 1, mk(8,0,0,0,0,0,1,4,5,6,0), 1, 6'h00, 5},
    // R6 vector prefix with 32-bit disp
    '{1, mk(3,0,0,0,0,0,1,2,3,1,0), 1, mk(7,1,1,0,1,0,1,4,5,6,0), 0, 6'h08, 6},
    // R6 mask prefix with 8-bit disp allowed
    '{1, mk(3,0,0,0,0,0,1,2,3,1,0), 1, mk(5,1,0,0,2,0,1,4,5,6,0), 1, 6'h00, 6},
    // R6 legacy prefix with 32-bit disp allowed
    '{1, mk(7,1,1,0,3,0,1,2,3,1,0), 1, mk(3,0,0,0,0,0,1,4,5,6,0), 1, 6'h00, 6},
    // R7 older microcoded
    '{1, mk(3,0,0,0,0,1,1,2,3,1,0), 1, mk(3,0,0,0,0,0,1,4,5,6,0), 0, 6'h10, 7},
    // R8 younger multi-cycle
    '{1, mk(3,0,0,0,0,0,1,2,3,1,0), 1, mk(3,0,0,0,0,0,0,4,5,6,5), 0, 6'h20, 8},
    // R9 ucode + long + dependency -> ucode
    '{1, mk(10,0,0,0,0,0,1,2,3,1,0), 1, mk(3,0,0,0,0,1,1,1,5,6,0), 0, 6'h10, 9},
    // R9 multi-cycle + long -> multi-cycle
    '{1, mk(3,0,0,0,0,0,0,2,3,1,0), 1, mk(12,0,0,0,0,0,1,4,5,6,0), 0, 6'h20, 9},
    // R9 long + disp+imm -> length
    '{1, mk(11,1,0,1,0,0,1,2,3,1,0), 1, mk(3,0,0,0,0,0,1,4,5,6,0), 0, 6'h04, 9},
    // R9 disp+imm + prefixed disp32 -> disp+imm
    '{1, mk(3,0,0,0,0,0,1,2,3,1,0), 1, mk(8,1,1,1,1,0,1,4,5,6,0), 0, 6'h02, 9},
    // R9 prefixed disp32 + dependency -> prefix
    '{1, mk(3,0,0,0,0,0,1,2,3,1,0), 1, mk(7,1,1,0,2,0,1,1,5,6,0), 0, 6'h08, 9},
    // R10 younger invalid
    '{1, mk(3,0,0,0,0,0,1,2,3,1,0), 0, mk(3,0,0,0,0,0,1,4,5,6,0), 0, 6'h00, 10},
    // R10 older invalid, younger would trip ucode
    '{0, mk(3,0,0,0,0,0,1,2,3,1,0), 1, mk(3,0,0,0,0,1,1,4,5,6,0), 0, 6'h00, 10},
    // R2 register 0 never matches
    '{1, mk(3,0,0,0,0,0,1,2,3,0,0), 1, mk(3,0,0,0,0,0,1,0,0,0,0), 1, 6'h00, 2}
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got grant/reason %b, expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(vec_t vv);
    uValid = vv.uv; uD = vv.u; vValid = vv.vv; vD = vv.v;
  endtask

  initial begin
    rstN = 1'b0;
    apply(VECS[0]);
    repeat (2) @(negedge clk);
    // R11 reset state despite a grantable pair on the inputs
    check("R11 reset", {pairGrant, pairReason}, 7'h00);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {pairGrant, pairReason}, {VECS[i].expG, VECS[i].expR});
    end

    // R11 one-cycle latency: outputs hold until the next edge
    apply(VECS[13]);
    @(negedge clk);
    check("R11 load blocked", {pairGrant, pairReason}, 7'h10);
    apply(VECS[0]);
    #2;
    check("R11 hold before edge", {pairGrant, pairReason}, 7'h10);
    @(negedge clk);
    check("R11 after edge", {pairGrant, pairReason}, 7'h40);

    // R11 reset mid-run clears a granted result
    rstN = 1'b0;
    @(negedge clk);
    check("R11 reset mid-run", {pairGrant, pairReason}, 7'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset release", {pairGrant, pairReason}, 7'h40);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule